// File: doc/BRIEF.md
# Supply Window Fault Filter

This block watches two already-synchronized comparator flags that describe a supply rail: one says the rail is above its under-voltage trip point, the other says the rail has crossed its over-voltage trip point. The rail is "in window" when the first flag is high and the second is low. The block tells a power sequencer when the rail has been in window long enough to allow a start-up. It also decides how an out-of-window event is handled once the output is running.

Two policies are selected by a configuration bit. With filtering off, which is the power-on setting of the configuration, any out-of-window sample raises an immediate, non-latching kill request in the same cycle. With filtering on, short excursions are ignored. An excursion that outlasts a programmable number of samples sets a latched fault. That fault holds the output off until a fault-reset pulse arrives while the rail is back in window.

Top module: `swf_window_guard`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `supply_ok` and `fault_latched` are 0.
- R2: A sample is in window when `uv_above`=1 and `ov_above`=0. `supply_ok` rises only after QUAL_CYCLES consecutive in-window samples. It falls in the cycle after any out-of-window sample.
- R3: With `filt_en`=0, `kill_now` is 1 in the same cycle as any out-of-window input and 0 otherwise. This policy never sets `fault_latched`.
- R4: With `filt_en`=1, `kill_now` stays 0. A run of at most `filt_len` consecutive out-of-window samples leaves `fault_latched` at 0.
- R5: With `filt_en`=1, the clock edge that samples the (`filt_len`+1)-th consecutive out-of-window sample sets `fault_latched`. A single in-window sample, or `filt_en`=0, restarts the count.
- R6: Once set, `fault_latched` stays 1 until an edge samples `fault_clr`=1 together with an in-window rail. A `fault_clr` pulse while the rail is out of window is ignored. Changing `filt_en` does not clear the latch.
- R7: While `fault_latched` is 1, `supply_ok` is 0. After the latch clears, the full QUAL_CYCLES qualification delay starts again.
- R8: With `filt_len`=0 and `filt_en`=1, the first out-of-window sample sets `fault_latched`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uv_above | input | 1 | Rail above under-voltage trip point (1 = good) |
| ov_above | input | 1 | Rail above over-voltage trip point (1 = bad) |
| filt_en | input | 1 | 1 selects the filtered latching policy |
| filt_len | input | CNT_W | Tolerated consecutive out-of-window samples |
| fault_clr | input | 1 | Fault reset pulse |
| supply_ok | output | 1 | Rail qualified for start-up |
| kill_now | output | 1 | Immediate shutdown request (unfiltered policy) |
| fault_latched | output | 1 | Latched fault request (filtered policy) |

## Verification
A filter count that is off by one shows at `fault_latched` exactly one edge early or late, at the boundary of a run of `filt_len` or `filt_len`+1 samples. A counter that fails to restart shows as a spurious latch after a broken run. A latch that clears at the wrong time shows at `fault_latched` on the edge of a `fault_clr` pulse given while the rail is out of window. A qualification counter that is not restarted shows as `supply_ok` rising before QUAL_CYCLES samples have passed after an excursion or a fault clear. Every one of these shows within one cycle of the stimulus that exposes it.

// File: rtl/swf_pkg.sv
package swf_pkg;
  typedef struct packed {
    logic oow;   // rail outside its window this sample
    logic kill;  // immediate shutdown request
  } swf_win_t;

  function automatic logic swf_out_of_window(input logic uv_above, input logic ov_above);
    return (!uv_above) || ov_above;
  endfunction
endpackage

// File: rtl/swf_window_cmp.sv
module swf_window_cmp
  import swf_pkg::*;
(
  input  logic     uv_above,
  input  logic     ov_above,
  input  logic     filt_en,
  output swf_win_t win
);
  always_comb begin
    win.oow  = swf_out_of_window(uv_above, ov_above);
    win.kill = win.oow && !filt_en;
  end
endmodule

// File: rtl/swf_qual_timer.sv
module swf_qual_timer #(
  parameter int QUAL_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic block_i,
  output logic ok_o
);
  localparam int QW = $clog2(QUAL_CYCLES + 1);
  localparam logic [QW-1:0] QMAX = QW'(QUAL_CYCLES);

  logic [QW-1:0] qcnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              qcnt <= '0;
    else if (restart_i)      qcnt <= '0;
    else if (qcnt != QMAX)   qcnt <= qcnt + 1'b1;
  end

  assign ok_o = (qcnt == QMAX) && !block_i;

  p_qual_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !ok_o);
  p_qual_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_o) |-> !$past(restart_i));
  p_qual_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    block_i |-> !ok_o);
endmodule

// File: rtl/swf_fault_filter.sv
module swf_fault_filter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             oow_i,
  input  logic             filt_en,
  input  logic [CNT_W-1:0] filt_len,
  input  logic             fault_clr,
  output logic             latched_o
);
  logic [CNT_W-1:0] cnt;
  logic             latched;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      latched <= 1'b0;
    end else if (latched) begin
      cnt <= '0;
      if (fault_clr && !oow_i) latched <= 1'b0;
    end else if (filt_en && oow_i) begin
      if (cnt == filt_len) begin
        latched <= 1'b1;
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
    end
  end

  assign latched_o = latched;

  p_set_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latched_o) |-> ($past(oow_i) && $past(filt_en)));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_o && !(fault_clr && !oow_i)) |=> latched_o);
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_o && fault_clr && !oow_i) |=> !latched_o);
  p_unfilt_no_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!latched_o && !filt_en) |=> !latched_o);
endmodule

// File: rtl/swf_window_guard.sv
module swf_window_guard
  import swf_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int QUAL_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uv_above,
  input  logic             ov_above,
  input  logic             filt_en,
  input  logic [CNT_W-1:0] filt_len,
  input  logic             fault_clr,
  output logic             supply_ok,
  output logic             kill_now,
  output logic             fault_latched
);
  swf_win_t win;
  logic     latched;

  swf_window_cmp u_cmp (
    .uv_above (uv_above),
    .ov_above (ov_above),
    .filt_en  (filt_en),
    .win      (win)
  );

  swf_fault_filter #(.CNT_W(CNT_W)) u_filt (
    .clk       (clk),
    .rst_n     (rst_n),
    .oow_i     (win.oow),
    .filt_en   (filt_en),
    .filt_len  (filt_len),
    .fault_clr (fault_clr),
    .latched_o (latched)
  );

  swf_qual_timer #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (win.oow || latched),
    .block_i   (latched),
    .ok_o      (supply_ok)
  );

  assign kill_now      = win.kill;
  assign fault_latched = latched;

  p_filtered_no_kill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    filt_en |-> !kill_now);
  p_ok_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    supply_ok |-> $past(uv_above) && !$past(ov_above));
endmodule

// File: tb/sim_swf_window_guard.sv
module sim_swf_window_guard;
  localparam int CW = 8;
  localparam int QC = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uv_above = 1'b1, ov_above = 1'b0, filt_en = 1'b0, fault_clr = 1'b0;
  logic [CW-1:0] filt_len = '0;
  logic supply_ok, kill_now, fault_latched;

  int checks = 0, failures = 0;
  int m_cnt = 0, m_q = 0;
  bit m_lat = 0;
  bit done = 0;

  always #10 clk = ~clk;

  swf_window_guard #(.CNT_W(CW), .QUAL_CYCLES(QC)) u0 (
    .clk(clk), .rst_n(rst_n), .uv_above(uv_above), .ov_above(ov_above),
    .filt_en(filt_en), .filt_len(filt_len), .fault_clr(fault_clr),
    .supply_ok(supply_ok), .kill_now(kill_now), .fault_latched(fault_latched)
  );

  function automatic bit exp_oow(bit u, bit o);
    return !u || o;
  endfunction
  function automatic bit exp_kill(bit u, bit o, bit en);
    return exp_oow(u, o) && !en;
  endfunction

  task automatic check(string tag, logic act, bit exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // model update for one clock edge, from the requirements
  task automatic model_edge(bit u, bit o, bit en, int len, bit clr);
    bit oow = exp_oow(u, o);
    bit lat_old = m_lat;
    if (m_lat) begin
      m_cnt = 0;
      if (clr && !oow) m_lat = 0;
    end else if (en && oow) begin
      if (m_cnt == len) begin m_lat = 1; m_cnt = 0; end
      else m_cnt++;
    end else m_cnt = 0;
    if (lat_old || oow) m_q = 0;
    else if (m_q != QC) m_q++;
  endtask

  // drive at negedge, check comb output, take edge, check state
  task automatic step(bit u, bit o, bit en, int len, bit clr);
    @(negedge clk);
    uv_above = u; ov_above = o; filt_en = en; filt_len = CW'(len); fault_clr = clr;
    #2;
    check(en ? "R4 kill" : "R3 kill", kill_now, exp_kill(u, o, en));
    @(posedge clk);
    model_edge(u, o, en, len, clr);
    #2;
    check("R5 latch", fault_latched, m_lat);
    check(m_lat ? "R7 ok" : "R2 ok", supply_ok, (m_q == QC) && !m_lat);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd7));
    repeat (3) @(posedge clk);
    #2;
    check("R1 ok reset", supply_ok, 1'b0);
    check("R1 latch reset", fault_latched, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    model_edge(1, 0, 0, 0, 0);
    check("R1 ok after reset", supply_ok, 1'b0);
    check("R1 latch after reset", fault_latched, 1'b0);

    // R2 qualification delay
    for (int i = 0; i < QC + 2; i++) step(1, 0, 0, 0, 0);
    check("R2 qualified", supply_ok, 1'b1);
    // R3 unfiltered immediate kill, no latch
    step(0, 0, 0, 3, 0);
    check("R3 no latch", fault_latched, 1'b0);
    check("R2 drop", supply_ok, 1'b0);
    step(1, 1, 0, 3, 0);
    for (int i = 0; i < QC + 1; i++) step(1, 0, 1, 3, 0);
    // R4 run of filt_len tolerated
    for (int i = 0; i < 3; i++) step(0, 0, 1, 3, 0);
    check("R4 glitch tolerated", fault_latched, 1'b0);
    step(1, 0, 1, 3, 0);
    // R5 run of filt_len+1 latches
    for (int i = 0; i < 4; i++) step(1, 1, 1, 3, 0);
    check("R5 sustained latch", fault_latched, 1'b1);
    // R6 clear while out of window ignored, filt_en change ignored
    step(1, 1, 0, 3, 1);
    check("R6 clr ignored", fault_latched, 1'b1);
    step(1, 0, 0, 3, 0);
    check("R6 held", fault_latched, 1'b1);
    check("R7 ok masked", supply_ok, 1'b0);
    step(1, 0, 1, 3, 1);
    check("R6 cleared", fault_latched, 1'b0);
    // R7 full requalification after clear
    for (int i = 0; i < QC - 1; i++) step(1, 0, 1, 3, 0);
    check("R7 not yet", supply_ok, 1'b0);
    step(1, 0, 1, 3, 0);
    check("R7 requalified", supply_ok, 1'b1);
    // R8 zero length
    step(0, 1, 1, 0, 0);
    check("R8 immediate latch", fault_latched, 1'b1);
    step(1, 0, 1, 0, 1);
    check("R8 cleared", fault_latched, 1'b0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      bit u = ($urandom % 8) != 0;
      bit o = ($urandom % 10) == 0;
      bit en = ($urandom % 4) != 0;
      int len = $urandom % 5;
      bit clr = ($urandom % 12) == 0;
      if ((i / 300) % 2 == 1) len = 2;
      step(u, o, en, len, clr);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule